// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a serial port that sits on the shared special-register bus of a small controller. Software reaches it through three registers: a control/status register (mode select, multiprocessor filter, receive enable, ninth bits and the two event flags), a data buffer (writing it sends a frame, reading it returns the last accepted frame) and a rate-doubling register that holds only a single bit. The port drives one interrupt line, which is high while either event flag is set.

Four modes are selected by the two top control bits. Mode 0 is a synchronous 8-bit shifter with its own shift clock at a fixed division of the system clock. Mode 1 exchanges 10-bit frames. Modes 2 and 3 exchange 11-bit frames whose ninth bit is programmable. Mode 2 runs at a fixed division of the system clock. Modes 1 and 3 take their rate from an external timer overflow pulse. In the asynchronous modes the receiver works at sixteen times the bit rate, takes a majority of three samples around mid-bit, and can drop frames by their ninth bit to filter addresses on a shared line.

Top module: `sercom_port`

## Requirements
- R1: After reset the control register reads 0x00, the rate register reads 0x00, `txd` and `sh_clk` are high and `irq` is low.
- R2: The control register sits at `SCON_ADDR` with bits 7..0 = mode high, mode low, filter enable, receive enable, transmit ninth bit, received ninth bit, transmit flag (bit 1), receive flag (bit 0). The mode number is {bit7,bit6}. The data buffer sits at `SBUF_ADDR`. The rate register sits at `PCON_ADDR`: only bit 7 (rate double) is stored, and the other bits read 0.
- R3: Mode 0 transmit sends the 8 data bits LSB first on `txd`, each bit lasting `M0_DIV` clocks. `sh_clk` is low for the first half of each bit and high for the second half. The transmit flag is set after the eighth bit ends.
- R4: Mode 1 transmit sends a low start bit, 8 data bits LSB first and a high stop bit. One bit lasts 64 timer overflow pulses when rate double is 0, and 32 when it is 1. The transmit flag is set once the stop bit has begun.
- R5: Mode 2 transmit sends start, 8 data bits LSB first, the transmit ninth bit, then stop. One bit lasts 64 clocks when rate double is 0, and 32 when it is 1.
- R6: Mode 3 transmit sends the 11-bit frame of R5 with the bit timing of R4.
- R7: With receive enabled, an asynchronous frame loads the data buffer and sets the receive flag. The received ninth bit takes the stop bit in mode 1 and the ninth data bit in modes 2 and 3.
- R8: A low pulse on `rxd` shorter than half a bit is rejected as noise and produces no reception.
- R9: In modes 2 and 3 with the filter enabled, a frame whose ninth bit is 0 changes neither the data buffer nor the receive flag. A frame whose ninth bit is 1 is accepted.
- R10: In mode 1 with the filter enabled, a frame with a low stop bit is discarded. With the filter disabled it is accepted, and the received ninth bit reads 0.
- R11: A frame that completes while the receive flag is still set is discarded, and the data buffer keeps its earlier value.
- R12: With receive disabled, frames on `rxd` produce no reception.
- R13: Mode 0 receive starts when receive is enabled and the receive flag is clear. It drives 8 periods on `sh_clk`, samples `rxd` at each rising edge of `sh_clk` (LSB first), then loads the data buffer and sets the receive flag.
- R14: `irq` is high exactly while the transmit or receive flag is set. Only a software write to the control register clears these flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| t1_ovf | input | 1 | One-clock pulse per timer overflow, sets the rate of modes 1 and 3 |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| sh_clk | output | 1 | Shift clock for mode 0 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the port with its default parameters: a 12-clock mode-0 bit, and register addresses 0x40, 0x41 and 0x42. It fires `t1_ovf` once every three clocks, so a timer-paced bit lasts 96 or 192 clocks, while mode 2 runs at 32 or 64 clocks per bit. Both rate-double settings and all four frame shapes can therefore be checked within a few thousand clocks each. The short bit times also put the filter, the discard cases and noise rejection within reach, because each needs several frames in a row.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_A10  = 2'd1,
    MODE_A11F = 2'd2,
    MODE_A11T = 2'd3
  } smode_e;

  // asynchronous receive/transmit ticks per bit
  localparam int OVS = 16;
  localparam int CW  = $clog2(OVS);
endpackage

// File: rtl/sercom_baud.sv
module sercom_baud
  import sercom_pkg::*;
#(
  parameter int M0_DIV = 12
) (
  input  logic   clk,
  input  logic   rst_n,
  input  smode_e mode,
  input  logic   smod,
  input  logic   t1_ovf,
  output logic   tick
);
  localparam int HALF = M0_DIV / 2;
  localparam int PW   = $clog2(HALF > 1 ? HALF : 2);

  logic [PW-1:0] m0_q, m0_d;
  logic [1:0]    pre_q, pre_d;
  logic          tick_d;
  logic          evt;
  logic [1:0]    lim;

  always_comb begin
    evt    = (mode == MODE_A11F) ? 1'b1 : t1_ovf;
    lim    = smod ? 2'd1 : 2'd3;
    m0_d   = m0_q;
    pre_d  = pre_q;
    tick_d = 1'b0;
    if (mode == MODE_SYNC) begin
      if (m0_q == PW'(HALF - 1)) begin
        m0_d   = '0;
        tick_d = 1'b1;
      end else begin
        m0_d = m0_q + 1'b1;
      end
    end else if (evt) begin
      if (pre_q >= lim) begin
        pre_d  = '0;
        tick_d = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_q  <= '0;
      pre_q <= '0;
      tick  <= 1'b0;
    end else begin
      m0_q  <= m0_d;
      pre_q <= pre_d;
      tick  <= tick_d;
    end
  end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  smode_e     mode,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       nin,
  output logic       txd,
  output logic       sclk,
  output logic       busy,
  output logic       ti_set
);
  localparam int FW = 11;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SEND} txst_e;

  txst_e         st_q, st_d;
  smode_e        md_q, md_d;
  logic [FW-1:0] shf_q, shf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [3:0]    last;
  logic [CW-1:0] cnt_last;

  always_comb begin
    st_d     = st_q;
    md_d     = md_q;
    shf_d    = shf_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    ti_set   = 1'b0;
    last     = (md_q == MODE_SYNC) ? 4'd7 : (md_q == MODE_A10) ? 4'd9 : 4'd10;
    cnt_last = (md_q == MODE_SYNC) ? CW'(1) : CW'(OVS - 1);
    case (st_q)
      TX_IDLE: if (start) begin
        st_d = TX_WAIT;
        md_d = mode;
        case (mode)
          MODE_SYNC: shf_d = {3'b111, data};
          MODE_A10:  shf_d = {2'b11, data, 1'b0};
          default:   shf_d = {1'b1, nin, data, 1'b0};
        endcase
      end
      TX_WAIT: if (tick) begin
        st_d  = TX_SEND;
        cnt_d = '0;
        idx_d = '0;
      end
      default: if (tick) begin
        if (cnt_q == cnt_last) begin
          cnt_d = '0;
          if (idx_q == last) begin
            st_d = TX_IDLE;
            if (md_q == MODE_SYNC) ti_set = 1'b1;
          end else begin
            idx_d = idx_q + 4'd1;
            shf_d = {1'b1, shf_q[FW-1:1]};
            if (md_q != MODE_SYNC && (idx_q + 4'd1) == last) ti_set = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      md_q  <= MODE_SYNC;
      shf_q <= '1;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      md_q  <= md_d;
      shf_q <= shf_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign txd  = (st_q == TX_SEND) ? shf_q[0] : 1'b1;
  assign sclk = !(st_q == TX_SEND && md_q == MODE_SYNC && cnt_q == '0);
  assign busy = (st_q != TX_IDLE);
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  smode_e     mode,
  input  logic       ren,
  input  logic       sm2,
  input  logic       ri,
  input  logic       rxd,
  output logic       load,
  output logic [7:0] rx_byte,
  output logic       rx_b9,
  output logic       sclk,
  output logic       busy
);
  localparam logic [CW-1:0] S0 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S1 = CW'(OVS / 2);
  localparam logic [CW-1:0] S2 = CW'(OVS / 2 + 1);
  typedef enum logic {RX_IDLE, RX_RECV} rxst_e;

  rxst_e         st_q, st_d;
  logic [1:0]    sy_q;
  logic          rxd_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [1:0]    v_q, v_d;
  logic [7:0]    byte_q, byte_d;
  logic          b9_q, b9_d;
  logic          maj;
  logic [3:0]    last;

  assign rxd_s = sy_q[1];

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    v_d    = v_q;
    byte_d = byte_q;
    b9_d   = b9_q;
    load   = 1'b0;
    rx_b9  = b9_q;
    maj    = (v_q[0] & v_q[1]) | (v_q[0] & rxd_s) | (v_q[1] & rxd_s);
    last   = (mode == MODE_A10) ? 4'd9 : 4'd10;
    if (tick) begin
      if (st_q == RX_IDLE) begin
        if (mode == MODE_SYNC) begin
          if (ren && !ri) begin
            st_d  = RX_RECV;
            cnt_d = '0;
            idx_d = '0;
          end
        end else if (ren && !rxd_s) begin
          st_d  = RX_RECV;
          cnt_d = CW'(1);
          idx_d = '0;
        end
      end else if (mode == MODE_SYNC) begin
        if (cnt_q == '0) begin
          cnt_d  = CW'(1);
          byte_d = {rxd_s, byte_q[7:1]};
        end else begin
          cnt_d = '0;
          if (idx_q == 4'd7) begin
            st_d = RX_IDLE;
            load = !ri;
          end else begin
            idx_d = idx_q + 4'd1;
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == S0) v_d[0] = rxd_s;
        if (cnt_q == S1) v_d[1] = rxd_s;
        if (cnt_q == S2) begin
          if (idx_q == 4'd0) begin
            if (maj) st_d = RX_IDLE;
          end else if (idx_q <= 4'd8) begin
            byte_d = {maj, byte_q[7:1]};
          end else if (idx_q == 4'd9 && last == 4'd10) begin
            b9_d = maj;
          end
          if (idx_q == last) begin
            rx_b9 = (mode == MODE_A10) ? maj : b9_q;
            load  = !ri && (!sm2 || rx_b9);
          end
        end
        if (cnt_q == CW'(OVS - 1)) begin
          cnt_d = '0;
          if (idx_q == last) st_d = RX_IDLE;
          else idx_d = idx_q + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q   <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      v_q    <= 2'b11;
      byte_q <= '0;
      b9_q   <= 1'b0;
    end else begin
      sy_q   <= {sy_q[0], rxd};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      v_q    <= v_d;
      byte_q <= byte_d;
      b9_q   <= b9_d;
    end
  end

  assign rx_byte = byte_q;
  assign sclk    = !(st_q == RX_RECV && mode == MODE_SYNC && cnt_q == '0);
  assign busy    = (st_q == RX_RECV);
endmodule

// File: rtl/sercom_port.sv
module sercom_port
  import sercom_pkg::*;
#(
  parameter int             AW        = 8,
  parameter int             M0_DIV    = 12,
  parameter logic [AW-1:0]  SCON_ADDR = AW'('h40),
  parameter logic [AW-1:0]  SBUF_ADDR = AW'('h41),
  parameter logic [AW-1:0]  PCON_ADDR = AW'('h42)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          t1_ovf,
  input  logic          rxd,
  output logic          txd,
  output logic          sh_clk,
  output logic          irq
);
  logic [1:0] rs_q;
  logic       rst_i;
  logic [7:0] scon_q, scon_d;
  logic [7:0] sbuf_rx_q, sbuf_rx_d;
  logic       smod_q, smod_d;
  logic       scon_we, sbuf_we, pcon_we;
  smode_e     mode;
  logic       tick;
  logic       tx_sclk, rx_sclk, tx_busy, rx_busy, ti_set;
  logic       rx_load, rx_b9;
  logic [7:0] rx_byte;

  // reset asserts at once and leaves in step with the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign scon_we = reg_we && (reg_addr == SCON_ADDR);
  assign sbuf_we = reg_we && (reg_addr == SBUF_ADDR);
  assign pcon_we = reg_we && (reg_addr == PCON_ADDR);
  assign mode    = smode_e'(scon_q[7:6]);

  sercom_baud #(.M0_DIV(M0_DIV)) u_baud (
    .clk(clk), .rst_n(rst_i), .mode(mode), .smod(smod_q),
    .t1_ovf(t1_ovf), .tick(tick)
  );

  sercom_tx u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .mode(mode), .start(sbuf_we),
    .data(reg_wdata), .nin(scon_q[3]), .txd(txd), .sclk(tx_sclk),
    .busy(tx_busy), .ti_set(ti_set)
  );

  sercom_rx u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .mode(mode), .ren(scon_q[4]),
    .sm2(scon_q[5]), .ri(scon_q[0]), .rxd(rxd), .load(rx_load),
    .rx_byte(rx_byte), .rx_b9(rx_b9), .sclk(rx_sclk), .busy(rx_busy)
  );

  always_comb begin
    scon_d    = scon_q;
    sbuf_rx_d = sbuf_rx_q;
    smod_d    = smod_q;
    if (scon_we) scon_d = reg_wdata;
    if (pcon_we) smod_d = reg_wdata[7];
    if (ti_set)  scon_d[1] = 1'b1;
    if (rx_load) begin
      scon_d[0] = 1'b1;
      if (mode != MODE_SYNC) scon_d[2] = rx_b9;
      sbuf_rx_d = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      scon_q    <= '0;
      sbuf_rx_q <= '0;
      smod_q    <= 1'b0;
    end else begin
      if (scon_we || ti_set || rx_load) scon_q <= scon_d;
      if (rx_load)                      sbuf_rx_q <= sbuf_rx_d;
      if (pcon_we)                      smod_q <= smod_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == SCON_ADDR)      reg_rdata = scon_q;
    else if (reg_addr == SBUF_ADDR) reg_rdata = sbuf_rx_q;
    else if (reg_addr == PCON_ADDR) reg_rdata = {smod_q, 7'b0};
  end

  assign sh_clk = tx_sclk & rx_sclk;
  assign irq    = scon_q[1] | scon_q[0];
endmodule

// File: rtl/sercom_chk.sv
module sercom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       sh_clk,
  input logic       tx_busy,
  input logic       rx_busy,
  input logic       ti,
  input logic       ri,
  input logic       scon_we,
  input logic       ti_set,
  input logic       rx_load,
  input logic [7:0] sbuf_rx
);
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_shclk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !rx_busy) |-> sh_clk);

  assert_ti_cause_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> $past(ti_set || scon_we));

  assert_ri_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(rx_load || scon_we));

  assert_keep_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sbuf_rx) |-> !$past(ri));
endmodule

bind sercom_port sercom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .sh_clk(sh_clk),
  .tx_busy(tx_busy), .rx_busy(rx_busy), .ti(scon_q[1]), .ri(scon_q[0]),
  .scon_we(scon_we), .ti_set(ti_set), .rx_load(rx_load), .sbuf_rx(sbuf_rx_q)
);

// File: tb/tb_sercom_port.sv
`timescale 1ns/1ps
module tb_sercom_port;
  localparam logic [7:0] A_SCON = 8'h40, A_SBUF = 8'h41, A_PCON = 8'h42;
  localparam int M0  = 12;
  localparam int T1K = 3;

  logic       clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = A_SCON, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       t1_ovf = 1'b0, rxd = 1'b1;
  logic       txd, sh_clk, irq;

  always #2.5 clk = ~clk;

  sercom_port #(.AW(8), .M0_DIV(M0), .SCON_ADDR(A_SCON), .SBUF_ADDR(A_SBUF),
                .PCON_ADDR(A_PCON)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t1_ovf(t1_ovf),
    .rxd(rxd), .txd(txd), .sh_clk(sh_clk), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  int pend = 0;
  int unsigned cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (T1K - 1) @(negedge clk);
    t1_ovf = 1'b1;
    @(negedge clk);
    t1_ovf = 1'b0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    int         mode;
    int         bitc;
    logic [7:0] data;
    logic       nin;
    string      req;
  } item_t;
  item_t exp_q[$];

  // monitor: decode txd and compare with the oldest expected frame
  initial forever begin
    item_t it;
    logic [7:0] got;
    logic ok_frame;
    wait (pend != 0);
    it = exp_q[0];
    got = 8'h00;
    ok_frame = 1'b1;
    if (it.mode == 0) begin
      int unsigned prev;
      prev = 0;
      for (int i = 0; i < 8; i++) begin
        @(posedge sh_clk);
        if (i > 0 && (cyc - prev) != M0) ok_frame = 1'b0;
        prev = cyc;
        @(negedge clk);
        got[i] = txd;
      end
      check({it.req, " mode0 data"}, got, it.data);
      check({it.req, " mode0 bit period"}, ok_frame, 1'b1);
    end else begin
      @(negedge txd);
      repeat (it.bitc / 2) @(negedge clk);
      check({it.req, " start bit"}, txd, 1'b0);
      for (int i = 0; i < 8; i++) begin
        repeat (it.bitc) @(negedge clk);
        got[i] = txd;
      end
      check({it.req, " data"}, got, it.data);
      if (it.mode >= 2) begin
        repeat (it.bitc) @(negedge clk);
        check({it.req, " ninth bit"}, txd, it.nin);
      end
      repeat (it.bitc) @(negedge clk);
      check({it.req, " stop bit"}, txd, 1'b1);
      check({it.req, " TI by stop mid-bit"}, reg_rdata[1], 1'b1);
    end
    void'(exp_q.pop_front());
    pend--;
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = A_SCON;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = A_SCON;
  endtask

  task automatic tx_frame(int mode, int bitc, logic [7:0] data, logic nin, string req);
    item_t it;
    it.mode = mode; it.bitc = bitc; it.data = data; it.nin = nin; it.req = req;
    exp_q.push_back(it);
    pend++;
    wr(A_SBUF, data);
    wait (pend == 0);
    repeat (bitc + 20) @(negedge clk);
  endtask

  task automatic rx_frame(int bitc, int nb, logic [7:0] data, logic b9, logic stp);
    @(negedge clk);
    rxd = 1'b0;
    repeat (bitc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = data[i];
      repeat (bitc) @(negedge clk);
    end
    if (nb == 11) begin
      rxd = b9;
      repeat (bitc) @(negedge clk);
    end
    rxd = stp;
    repeat (bitc) @(negedge clk);
    rxd = 1'b1;
    repeat (bitc + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_SCON, v); check("R1 control reset", v, 8'h00);
    rd(A_PCON, v); check("R1 rate reset", v, 8'h00);
    check("R1 txd idle", txd, 1'b1);
    check("R1 sh_clk idle", sh_clk, 1'b1);
    check("R1 irq low", irq, 1'b0);

    // R2 rate register keeps bit 7 only
    wr(A_PCON, 8'hFF);
    rd(A_PCON, v); check("R2 rate register", v, 8'h80);

    // R5 mode 2, rate double on, ninth 1
    wr(A_SCON, 8'h88);
    tx_frame(2, 32, 8'hA5, 1'b1, "R5");
    check("R14 irq with TI", irq, 1'b1);
    wr(A_SCON, 8'h80);
    check("R14 irq cleared", irq, 1'b0);
    // R5 rate double off, ninth 0
    wr(A_PCON, 8'h00);
    tx_frame(2, 64, 8'h3C, 1'b0, "R5");
    // R4 mode 1 on timer pulses, rate double on
    wr(A_PCON, 8'h80);
    wr(A_SCON, 8'h40);
    tx_frame(1, 16 * 2 * T1K, 8'h81, 1'b0, "R4");
    // R6 mode 3, rate double off
    wr(A_PCON, 8'h00);
    wr(A_SCON, 8'hC8);
    tx_frame(3, 16 * 4 * T1K, 8'h5A, 1'b1, "R6");
    // R3 mode 0 transmit
    wr(A_SCON, 8'h00);
    tx_frame(0, M0, 8'hC3, 1'b0, "R3");
    rd(A_SCON, v); check("R3 TI after eighth bit", v[1], 1'b1);
    wr(A_SCON, 8'h00);

    // R7 mode 2 receive
    wr(A_PCON, 8'h80);
    wr(A_SCON, 8'h90);
    rx_frame(32, 11, 8'h96, 1'b1, 1'b1);
    rd(A_SBUF, v); check("R7 mode2 data", v, 8'h96);
    rd(A_SCON, v); check("R7 mode2 RI and RB8", v[2:0], 3'b101);
    check("R14 irq with RI", irq, 1'b1);
    // R8 short low pulse
    wr(A_SCON, 8'h90);
    @(negedge clk); rxd = 1'b0;
    repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (400) @(negedge clk);
    rd(A_SCON, v); check("R8 glitch ignored", v[0], 1'b0);
    // R9 filter
    wr(A_SCON, 8'hB0);
    rx_frame(32, 11, 8'h11, 1'b0, 1'b1);
    rd(A_SCON, v); check("R9 ninth 0 no RI", v[0], 1'b0);
    rd(A_SBUF, v); check("R9 ninth 0 buffer kept", v, 8'h96);
    rx_frame(32, 11, 8'h22, 1'b1, 1'b1);
    rd(A_SBUF, v); check("R9 ninth 1 accepted", v, 8'h22);
    // R11 frame while RI set
    rx_frame(32, 11, 8'h33, 1'b1, 1'b1);
    rd(A_SBUF, v); check("R11 buffer kept while RI", v, 8'h22);
    // R12 receive disabled
    wr(A_SCON, 8'h80);
    rx_frame(32, 11, 8'h44, 1'b1, 1'b1);
    rd(A_SCON, v); check("R12 no RI", v[0], 1'b0);
    rd(A_SBUF, v); check("R12 buffer kept", v, 8'h22);
    // R7 / R10 mode 1 on timer pulses
    wr(A_SCON, 8'h50);
    rx_frame(16 * 2 * T1K, 10, 8'h4E, 1'b0, 1'b1);
    rd(A_SBUF, v); check("R7 mode1 data", v, 8'h4E);
    rd(A_SCON, v); check("R7 mode1 RB8 stop", v[2:0], 3'b101);
    wr(A_SCON, 8'h70);
    rx_frame(16 * 2 * T1K, 10, 8'h55, 1'b0, 1'b0);
    rd(A_SCON, v); check("R10 bad stop discarded", v[0], 1'b0);
    rd(A_SBUF, v); check("R10 buffer kept", v, 8'h4E);
    wr(A_SCON, 8'h50);
    rx_frame(16 * 2 * T1K, 10, 8'h66, 1'b0, 1'b0);
    rd(A_SBUF, v); check("R10 no filter accepted", v, 8'h66);
    rd(A_SCON, v); check("R10 RB8 zero", v[2:0], 3'b001);

    // R13 mode 0 receive
    wr(A_SCON, 8'h00);
    rxd = 1'b1;
    wr(A_SCON, 8'h10);
    for (int i = 1; i < 8; i++) begin
      @(posedge sh_clk);
      #1 rxd = v[0] ? 1'b1 : 1'b1;
      rxd = (8'h6D >> i) & 8'h01;
    end
    @(posedge sh_clk);
    repeat (30) @(negedge clk);
    rxd = 1'b1;
    rd(A_SBUF, v); check("R13 mode0 data", v, 8'h6D);
    rd(A_SCON, v); check("R13 mode0 RI", v[0], 1'b1);
    wr(A_SCON, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // bit 0 of the mode-0 pattern must be on rxd before reception starts
  initial begin
    wait (reg_we && reg_addr == A_SCON && reg_wdata == 8'h10);
    rxd = 1'b1;
  end
endmodule